// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns bytes taken from an external transmit queue into asynchronous serial frames on a single output line. Every frame begins with a low start bit. The data bits follow, least significant first, and the word length can be 5 to 8 bits. An optional parity bit comes next, which can be odd, even or forced to a fixed level. The frame ends with one, one and a half, or two high stop bits. Timing comes from a half-bit tick: each bit lasts two ticks, and this makes the one-and-a-half stop bit an exact length.

Several controls sit around the framing logic:

- A programmable number of idle bit times can be placed between the end of one frame and the start of the next.
- An optional clear-to-send input, with selectable active level, holds back new frames.
- A break control forces the line low while the sequencer keeps running.
- An inversion control flips the output pin.
- A registered flag reports when the queue is empty and the last stop bit has finished.

The queue storage, the register interface and any infrared pulse shaping sit outside the block. The queue reports its head byte and an empty indication. The block answers with a one-cycle pop strobe each time it takes a byte.

Top module: `serial_tx_engine`

## Requirements
- R1: The line idles at 1. A frame is one start bit at 0, then the data bits least significant first, then the stop bits at 1. Each bit lasts exactly two half-bit ticks.
- R2: The word length code selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8.
- R3: With the stop select clear, a frame has one stop bit. With it set, a frame has 1.5 stop bits (3 ticks) for a 5-bit word and 2 stop bits for 6, 7 or 8 bits.
- R4: With parity enabled and stick mode off, one parity bit follows the data. With the even select set, the parity bit makes the total count of ones among data and parity even. With it clear, that count is odd.
- R5: With parity and stick mode both enabled, the parity bit is a constant 0 when the even select is set and a constant 1 when it is clear.
- R6: A frame starts only on a tick. With a gap of 0, a queued byte starts on the tick at which the previous frame's last stop tick ends, so no idle time lies between the frames.
- R7: A gap value N (8 bits) places exactly 2N ticks of idle line between the end of a stop bit and the next start bit.
- R8: With clear-to-send gating enabled, no frame starts unless the clear-to-send pin is at its active level. The active level is high when the polarity select is 0 and low when it is 1. A deassertion during a frame does not cut that frame short.
- R9: While break is set, the line is forced to 0 before inversion. The frame sequencing and its duration are unchanged.
- R10: With inversion set, the output pin is the complement of the line level.
- R11: The empty flag is 1 only when the queue is empty and no start, data, parity or stop bit is in progress. For an 8-bit frame with no parity and one stop bit, the flag rises exactly 20 ticks after the tick that loaded the byte.
- R12: The pop strobe is a single-cycle pulse. It comes one cycle after a byte is loaded at the start of its frame, and only for a byte that was present in the queue.
- R13: During and right after reset, the pin is 1, the pop strobe is 0 and the empty flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick | input | 1 | Single-cycle pulse at twice the bit rate |
| q_data | input | 8 | Byte at the head of the transmit queue |
| q_empty | input | 1 | Transmit queue holds no byte |
| q_pop | output | 1 | Takes the head byte from the queue |
| word_len | input | 2 | Data bit count minus 5 |
| stop_long | input | 1 | Selects the longer stop period |
| par_en | input | 1 | Adds a parity bit |
| par_even | input | 1 | Even parity select, or the stick level select |
| par_stick | input | 1 | Fixed-level parity |
| brk_force | input | 1 | Forces the line to the spacing level |
| gap_bits | input | 8 | Idle bit times between frames |
| cts_in | input | 1 | Clear-to-send pin |
| cts_gate | input | 1 | Enables clear-to-send gating |
| cts_low_act | input | 1 | Clear-to-send is active low |
| out_inv | input | 1 | Inverts the output pin |
| txd | output | 1 | Serial output pin |
| tx_done | output | 1 | Queue empty and line finished |

## Verification
The main function is driven with several byte values at every word length. These include alternating patterns and a lone set bit, so that a reversed bit order or a truncated word stands out. The frames are also run through each parity flavour: odd, even, stick-0 and stick-1, with data whose ones count makes odd and even parity disagree. Stop lengths are tried with a 5-bit word and with a longer word, which separates the half-bit case from the full-bit case. Paired bytes sent back to back, and with a nonzero gap, show whether the idle time is zero, exactly 2N ticks, or off by a tick. Clear-to-send is held inactive, asserted, and dropped mid-frame under both polarities. Break and inversion are checked against the same frame duration as a normal frame.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4,
        ST_GAP   = 3'd5
    } tx_state_e;

    localparam int unsigned MIN_BITS   = 5;
    localparam int unsigned TICKS_BIT  = 2;

endpackage

// File: rtl/sertx_parity.sv
module sertx_parity #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic [1:0]    len_code,
    input  logic          even_sel,
    input  logic          stick,
    output logic          par_bit
);
    localparam int unsigned CW = $clog2(DW + 1);

    logic [DW-1:0] mask;
    logic [CW-1:0] nbits;
    logic          ones_odd;

    assign nbits = CW'(sertx_pkg::MIN_BITS) + CW'(len_code);

    always_comb begin
        for (int i = 0; i < DW; i++) begin
            mask[i] = (CW'(i) < nbits);
        end
        ones_odd = ^(data & mask);
        if (stick) begin
            par_bit = ~even_sel;
        end else begin
            par_bit = even_sel ? ones_odd : ~ones_odd;
        end
    end

endmodule

// File: rtl/sertx_elem_len.sv
module sertx_elem_len #(
    parameter int unsigned GAP_W = 8
) (
    input  sertx_pkg::tx_state_e state,
    input  logic [1:0]           len_code,
    input  logic                 stop_long,
    input  logic [GAP_W-1:0]     gap,
    output logic [GAP_W:0]       len
);
    localparam logic [GAP_W:0] ONE_BIT = (GAP_W+1)'(sertx_pkg::TICKS_BIT);

    always_comb begin
        unique case (state)
            sertx_pkg::ST_STOP: begin
                if (!stop_long)            len = ONE_BIT;
                else if (len_code == 2'd0) len = (GAP_W+1)'(3);
                else                       len = (GAP_W+1)'(4);
            end
            sertx_pkg::ST_GAP: len = {gap, 1'b0};
            default:           len = ONE_BIT;
        endcase
    end

endmodule

// File: rtl/sertx_line_drv.sv
module sertx_line_drv (
    input  logic line,
    input  logic brk,
    input  logic inv,
    output logic pin
);
    assign pin = (brk ? 1'b0 : line) ^ inv;
endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine #(
    parameter int unsigned DW    = 8,
    parameter int unsigned GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_tick,
    input  logic [DW-1:0]    q_data,
    input  logic             q_empty,
    output logic             q_pop,
    input  logic [1:0]       word_len,
    input  logic             stop_long,
    input  logic             par_en,
    input  logic             par_even,
    input  logic             par_stick,
    input  logic             brk_force,
    input  logic [GAP_W-1:0] gap_bits,
    input  logic             cts_in,
    input  logic             cts_gate,
    input  logic             cts_low_act,
    input  logic             out_inv,
    output logic             txd,
    output logic             tx_done
);
    import sertx_pkg::*;

    localparam int unsigned CNT_W = GAP_W + 1;
    localparam int unsigned IDX_W = $clog2(DW);

    typedef struct packed {
        tx_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    shreg;
        logic             par;
        logic             pin;
        logic             pop;
        logic             done;
    } tx_regs_t;

    tx_regs_t r_q, r_d;

    logic [CNT_W-1:0] elem_len;
    logic             load_par;
    logic             line;
    logic             pin_next;
    logic             cts_ok;
    logic             can_load;
    logic             last_tick;
    logic [IDX_W-1:0] last_idx;

    sertx_parity #(.DW(DW)) i_parity (
        .data     (q_data),
        .len_code (word_len),
        .even_sel (par_even),
        .stick    (par_stick),
        .par_bit  (load_par)
    );

    sertx_elem_len #(.GAP_W(GAP_W)) i_len (
        .state     (r_q.state),
        .len_code  (word_len),
        .stop_long (stop_long),
        .gap       (gap_bits),
        .len       (elem_len)
    );

    sertx_line_drv i_drv (
        .line (line),
        .brk  (brk_force),
        .inv  (out_inv),
        .pin  (pin_next)
    );

    assign cts_ok    = !cts_gate || (cts_in ^ cts_low_act);
    assign can_load  = !q_empty && cts_ok;
    assign last_tick = half_tick && (r_q.cnt == elem_len - CNT_W'(1));
    assign last_idx  = IDX_W'(MIN_BITS - 1) + IDX_W'(word_len);

    always_comb begin
        unique case (r_q.state)
            ST_START: line = 1'b0;
            ST_DATA:  line = r_q.shreg[0];
            ST_PAR:   line = r_q.par;
            default:  line = 1'b1;
        endcase
    end

    always_comb begin
        r_d     = r_q;
        r_d.pop = 1'b0;
        if (half_tick && r_q.state != ST_IDLE) begin
            r_d.cnt = last_tick ? '0 : r_q.cnt + CNT_W'(1);
        end
        unique case (r_q.state)
            ST_IDLE: begin
                if (half_tick && can_load) r_d.state = ST_START;
            end
            ST_START: begin
                if (last_tick) begin
                    r_d.state = ST_DATA;
                    r_d.idx   = '0;
                end
            end
            ST_DATA: begin
                if (last_tick) begin
                    r_d.shreg = r_q.shreg >> 1;
                    r_d.idx   = r_q.idx + IDX_W'(1);
                    if (r_q.idx == last_idx) begin
                        r_d.state = par_en ? ST_PAR : ST_STOP;
                    end
                end
            end
            ST_PAR: begin
                if (last_tick) r_d.state = ST_STOP;
            end
            ST_STOP: begin
                if (last_tick) begin
                    if (gap_bits != '0) r_d.state = ST_GAP;
                    else                r_d.state = can_load ? ST_START : ST_IDLE;
                end
            end
            ST_GAP: begin
                if (last_tick) r_d.state = can_load ? ST_START : ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
        if (r_d.state == ST_START && r_q.state != ST_START) begin
            r_d.shreg = q_data;
            r_d.par   = load_par;
            r_d.pop   = 1'b1;
            r_d.cnt   = '0;
        end
        r_d.pin  = pin_next;
        r_d.done = q_empty && (r_d.state == ST_IDLE || r_d.state == ST_GAP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.pin   <= 1'b1;
            r_q.done  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign txd     = r_q.pin;
    assign q_pop   = r_q.pop;
    assign tx_done = r_q.done;

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
    input logic clk,
    input logic rst_n,
    input logic q_empty,
    input logic q_pop,
    input logic cts_in,
    input logic cts_gate,
    input logic cts_low_act,
    input logic brk_force,
    input logic out_inv,
    input logic txd,
    input logic tx_done
);
    AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |=> !q_pop); // R12

    AST_POP_HAS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && q_pop |-> !$past(q_empty)); // R12

    AST_CTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && q_pop && $past(cts_gate) |-> ($past(cts_in) ^ $past(cts_low_act))); // R8

    AST_BREAK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(brk_force) |-> (txd == $past(out_inv))); // R9

    AST_DONE_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && tx_done |-> $past(q_empty)); // R11

    AST_DONE_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |-> !tx_done); // R11
endmodule

bind serial_tx_engine sertx_checker i_sertx_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .q_empty     (q_empty),
    .q_pop       (q_pop),
    .cts_in      (cts_in),
    .cts_gate    (cts_gate),
    .cts_low_act (cts_low_act),
    .brk_force   (brk_force),
    .out_inv     (out_inv),
    .txd         (txd),
    .tx_done     (tx_done)
);

// File: tb/test_serial_tx_engine.sv
module test_serial_tx_engine;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    typedef struct {
        logic [31:0] bits;
        int          len;
        logic [7:0]  data;
        string       req;
    } frame_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_tick = 1'b0;
    logic [7:0] q_data = '0;
    logic       q_empty = 1'b1;
    logic       q_pop;
    logic [1:0] word_len = 2'd3;
    logic       stop_long = 1'b0, par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
    logic       brk_force = 1'b0;
    logic [7:0] gap_bits = '0;
    logic       cts_in = 1'b0, cts_gate = 1'b0, cts_low_act = 1'b0, out_inv = 1'b0;
    logic       txd, tx_done;

    int checks = 0, fails = 0, pops = 0;
    bit finished = 0;
    logic [7:0] txq[$];
    frame_t     expq[$];

    bit          mon_en = 1;
    bit          in_frame = 0;
    int          idx = 0, idle_run = 0, last_gap = -1;
    logic [31:0] got_bits;
    frame_t      cur;

    serial_tx_engine i_serial_tx_engine (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .q_data(q_data), .q_empty(q_empty),
        .q_pop(q_pop), .word_len(word_len), .stop_long(stop_long), .par_en(par_en),
        .par_even(par_even), .par_stick(par_stick), .brk_force(brk_force), .gap_bits(gap_bits),
        .cts_in(cts_in), .cts_gate(cts_gate), .cts_low_act(cts_low_act), .out_inv(out_inv),
        .txd(txd), .tx_done(tx_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            c = (c + 1) % TICK_DIV;
            half_tick = (c == 0);
        end
    end

    // queue model: pop consumed at the edge, outputs refreshed at the falling edge
    always @(posedge clk) begin
        if (q_pop && txq.size() > 0) begin
            void'(txq.pop_front());
            pops++;
        end
    end
    always @(negedge clk) begin
        q_empty = (txq.size() == 0);
        q_data  = (txq.size() > 0) ? txq[0] : 8'h00;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic calc_par(input logic [7:0] d);
        logic ones = 1'b0;
        for (int i = 0; i < int'(word_len) + 5; i++) ones ^= d[i];
        if (par_stick) return ~par_even;
        return par_even ? ones : ~ones;
    endfunction

    task automatic send(input logic [7:0] d, input string req);
        frame_t f;
        int n = 0;
        f.bits = '0; f.data = d; f.req = req;
        n += 2;
        for (int i = 0; i < int'(word_len) + 5; i++) begin
            f.bits[n] = d[i]; f.bits[n+1] = d[i]; n += 2;
        end
        if (par_en) begin
            f.bits[n] = calc_par(d); f.bits[n+1] = calc_par(d); n += 2;
        end
        for (int i = 0; i < (!stop_long ? 2 : (word_len == 2'd0 ? 3 : 4)); i++) begin
            f.bits[n] = 1'b1; n++;
        end
        f.len = n;
        expq.push_back(f);
        txq.push_back(d);
    endtask

    // monitor: one line sample per half-bit, taken mid-way through it
    initial begin
        logic s;
        forever begin
            @(posedge clk);
            if (half_tick) begin
                @(posedge clk);
                @(negedge clk);
                s = txd ^ out_inv;
                if (mon_en) begin
                    if (!in_frame) begin
                        if (s == 1'b0) begin
                            if (expq.size() == 0) begin
                                chk(0, "R1 unexpected start", 0, 1);
                            end else begin
                                cur = expq.pop_front();
                                last_gap = idle_run;
                                got_bits = '0;
                                got_bits[0] = s;
                                idx = 1;
                                in_frame = 1;
                            end
                        end else begin
                            idle_run++;
                        end
                    end else begin
                        got_bits[idx] = s;
                        idx++;
                        if (idx == cur.len) begin
                            chk(got_bits == cur.bits, cur.req, int'(got_bits), int'(cur.bits));
                            in_frame = 0;
                            idle_run = 0;
                        end
                    end
                end
            end
        end
    end

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!half_tick) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (txq.size() != 0 || expq.size() != 0 || in_frame || !tx_done) @(negedge clk);
        wait_ticks(4);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        int p0;
        repeat (5) @(negedge clk);
        chk(txd == 1'b1 && q_pop == 1'b0 && tx_done == 1'b1, "R13 in reset", {txd, q_pop, tx_done}, 3'b101);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1 && q_pop == 1'b0 && tx_done == 1'b1, "R13 after reset", {txd, q_pop, tx_done}, 3'b101);

        // 8N1, back to back
        word_len = 2'd3;
        send(8'hA5, "R1 8N1 A5");
        send(8'h3C, "R1 8N1 3C");
        send(8'h01, "R1 8N1 01");
        wait_idle();
        chk(last_gap == 0, "R6 back-to-back gap", last_gap, 0);
        chk(pops == 3, "R12 pop count", pops, 3);

        // word lengths
        word_len = 2'd0; send(8'hF5, "R2 5-bit");  wait_idle();
        word_len = 2'd1; send(8'hEA, "R2 6-bit");  wait_idle();
        word_len = 2'd2; send(8'h95, "R2 7-bit");  wait_idle();

        // stop lengths
        stop_long = 1'b1;
        word_len = 2'd0; send(8'h0B, "R3 5-bit 1.5 stop"); send(8'h14, "R3 5-bit 1.5 stop b"); wait_idle();
        word_len = 2'd2; send(8'h4D, "R3 7-bit 2 stop"); wait_idle();
        stop_long = 1'b0;

        // parity flavours
        par_en = 1'b1;
        word_len = 2'd3; par_even = 1'b0; send(8'h07, "R4 odd parity");  wait_idle();
        par_even = 1'b1; send(8'h07, "R4 even parity"); send(8'h81, "R4 even parity 81"); wait_idle();
        word_len = 2'd1; par_even = 1'b0; send(8'hC3, "R4 odd 6-bit"); wait_idle();
        par_stick = 1'b1;
        word_len = 2'd3; par_even = 1'b1; send(8'h01, "R5 stick zero"); wait_idle();
        par_even = 1'b0; send(8'h03, "R5 stick one");  wait_idle();
        par_stick = 1'b0; par_en = 1'b0;

        // inter-frame gap
        gap_bits = 8'd3;
        send(8'h5A, "R7 gap first"); send(8'hA5, "R7 gap second"); wait_idle();
        chk(last_gap == 6, "R7 gap of 3 bits", last_gap, 6);
        gap_bits = 8'd0;

        // clear-to-send, active low
        cts_gate = 1'b1; cts_low_act = 1'b1; cts_in = 1'b1;
        p0 = pops;
        send(8'h55, "R8 low-active frame");
        wait_ticks(40);
        chk(pops == p0 && txd == 1'b1 && in_frame == 0, "R8 held by inactive cts", pops - p0, 0);
        chk(tx_done == 1'b0, "R11 not done with queued byte", tx_done, 0);
        cts_in = 1'b0;
        while (!q_pop) @(negedge clk);
        wait_ticks(3);
        cts_in = 1'b1;
        wait_idle();
        chk(pops == p0 + 1, "R8 frame finished after drop", pops - p0, 1);
        // active high
        cts_low_act = 1'b0; cts_in = 1'b0;
        p0 = pops;
        send(8'h33, "R8 high-active frame");
        wait_ticks(30);
        chk(pops == p0, "R8 held by low cts", pops - p0, 0);
        cts_in = 1'b1;
        wait_idle();
        chk(pops == p0 + 1, "R8 released by high cts", pops - p0, 1);
        cts_gate = 1'b0;

        // done timing on a plain frame
        send(8'hC6, "R11 timing frame");
        while (!q_pop) @(negedge clk);
        n = 0;
        while (!tx_done) begin @(posedge clk); if (half_tick) n++; @(negedge clk); end
        chk(n == 20, "R11 done after 20 ticks", n, 20);
        wait_idle();

        // break during a frame
        mon_en = 0;
        brk_force = 1'b1;
        wait_ticks(2);
        chk(txd == 1'b0, "R9 break at idle", txd, 0);
        txq.push_back(8'hFF);
        while (!q_pop) @(negedge clk);
        n = 0;
        p0 = 0;
        while (!tx_done) begin
            @(posedge clk); if (half_tick) n++; @(negedge clk);
            if (txd != 1'b0) p0++;
        end
        chk(p0 == 0, "R9 line low through frame", p0, 0);
        chk(n == 20, "R9 sequencing unchanged", n, 20);
        out_inv = 1'b1;
        wait_ticks(2);
        chk(txd == 1'b1, "R9 break before inversion", txd, 1);
        brk_force = 1'b0;
        wait_ticks(2);
        mon_en = 1;

        // inverted output
        chk(txd == 1'b0, "R10 inverted idle", txd, 0);
        send(8'h96, "R10 inverted frame");
        wait_idle();
        out_inv = 1'b0;
        wait_ticks(2);
        chk(txd == 1'b1, "R10 inversion removed", txd, 1);

        finish_run();
    end
endmodule